// File: doc/BRIEF.md
# Smart card character receiver with convention decoding

This block turns the serial I/O line of a smart card into bytes. It rebuilds each character from an oversampling strobe: `OSR` pulses of `bit_tick` make one elementary time unit (etu). A character is a start bit, eight data bits and a parity bit. The bits are decoded under either direct or inverse convention and the parity is checked, even or odd. The decoded byte is then stored in a small receive FIFO. The FIFO raises a read interrupt once its fill level goes above a programmable threshold. The FIFO holds `DEPTH` bytes, eight by default.

The first character after reset is the initial convention byte. The block compares it against the two legal patterns and reports whether it matched, and which convention it names. Software then programs `cfg_inverse` for the rest of the exchange. After reset the receiver decodes in direct convention, so that the initial byte can always be read.

Transmit, character retry handshaking and protocol parsing are not part of this block. `io_line` must already be synchronised to `clk`.

Top module: `card_rx_top`

## Requirements
- R1: After reset, `rx_level`, `rx_irq`, `parity_err`, `overrun`, `ts_seen`, `ts_valid` and `ts_inverse` are all 0.
- R2: A falling edge on `io_line` only starts a character if the line is still low half an etu later. A low pulse shorter than half an etu stores nothing.
- R3: With `cfg_inverse`=0, the first data bit on the line is bit 0 of the byte, and a high line level is a 1.
- R4: With `cfg_inverse`=1, the first data bit on the line is bit 7 of the byte, and a low line level is a 1. The parity bit is inverted in the same way.
- R5: With `cfg_odd_parity`=0, the eight data bits plus the decoded parity bit must hold an even number of ones; with 1, an odd number. On a mismatch, `parity_err` pulses for one cycle, and the byte is still stored.
- R6: Bytes leave in arrival order. A one-cycle `rd_en` pulse removes the byte shown on `rd_data`. `rd_en` while `rx_level` is 0 has no effect.
- R7: A character that completes while `rx_level` equals `DEPTH` is discarded. `overrun` pulses for one cycle, and the level and the stored bytes are unchanged.
- R8: `rx_irq` is 1 exactly while `rx_level` is greater than `cfg_tide` (0 to 7). At threshold 0 it rises with the first stored byte.
- R9: The first character after reset is decoded both ways, whatever `cfg_inverse` says. If it reads 0x3B in direct form, `ts_valid`=1 and `ts_inverse`=0. If it reads 0x3F in inverse form (0x03 in direct form), `ts_valid`=1 and `ts_inverse`=1. Any other byte gives `ts_valid`=0. In every case `ts_seen` becomes 1.
- R10: After `ts_seen` is set, later characters do not change `ts_seen`, `ts_valid` or `ts_inverse` until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_line | input | 1 | Synchronised card I/O line level |
| bit_tick | input | 1 | Oversampling strobe, OSR pulses per etu |
| cfg_inverse | input | 1 | 0 direct convention, 1 inverse convention |
| cfg_odd_parity | input | 1 | 0 even parity, 1 odd parity |
| cfg_tide | input | 3 | Read interrupt threshold |
| rd_en | input | 1 | Remove the head byte from the FIFO |
| rd_data | output | 8 | Head byte of the FIFO |
| rx_level | output | 4 | Number of bytes stored |
| rx_irq | output | 1 | Read interrupt |
| parity_err | output | 1 | One-cycle pulse for a character with bad parity |
| overrun | output | 1 | One-cycle pulse for a character dropped on a full FIFO |
| ts_seen | output | 1 | Initial character has been received |
| ts_valid | output | 1 | Initial character was a legal convention byte |
| ts_inverse | output | 1 | Initial character named inverse convention |

## Verification
The hardest state to reach is a character arriving on an already full FIFO, while the interrupt threshold sits at each of its eight settings. Only a long run of complete serial frames with no reads in between gets there.

The bench sweeps every threshold value. For each one it sends nine frames back to back, with the convention and parity mode changing from one threshold to the next. It checks the level and the interrupt after every frame, and the drop on the ninth frame. It then drains the FIFO and compares each byte against values computed arithmetically in the bench.

// File: rtl/card_rx_pkg.sv
package card_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2
  } rx_state_e;

  localparam logic [7:0] CONV_BYTE_DIRECT  = 8'h3B;
  localparam logic [7:0] CONV_BYTE_INVERSE = 8'h3F;

  // Turn bits in line order (first received at index 0) into a byte.
  function automatic logic [7:0] map_bits(input logic [7:0] line_bits,
                                          input logic       inverse);
    logic [7:0] res;
    for (int i = 0; i < 8; i++) begin
      res[i] = inverse ? ~line_bits[7-i] : line_bits[i];
    end
    return res;
  endfunction

endpackage

// File: rtl/card_rx_deser.sv
module card_rx_deser
  import card_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line,
  input  logic       tick,
  input  logic       inverse,
  input  logic       odd_par,
  output logic       chr_valid,
  output logic [7:0] chr_data,
  output logic [7:0] chr_raw,
  output logic       chr_perr
);

  localparam int CNTW = (OSR > 2) ? $clog2(OSR) : 1;
  localparam logic [CNTW-1:0] CNT_HALF = CNTW'(OSR / 2 - 1);
  localparam logic [CNTW-1:0] CNT_FULL = CNTW'(OSR - 1);

  rx_state_e       state;
  logic [CNTW-1:0] cnt;
  logic [3:0]      idx;
  logic [7:0]      sh;
  logic            line_prev;

  logic [7:0]      dec_now;
  logic            par_now;
  logic            perr_now;

  // Decode of the frame being closed: sh holds the data bits, line the parity bit.
  always_comb begin
    dec_now  = map_bits(sh, inverse);
    par_now  = inverse ? ~line : line;
    perr_now = (^dec_now) ^ par_now ^ odd_par;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RX_IDLE;
      cnt       <= '0;
      idx       <= '0;
      sh        <= '0;
      line_prev <= 1'b1;
      chr_valid <= 1'b0;
      chr_data  <= '0;
      chr_raw   <= '0;
      chr_perr  <= 1'b0;
    end else begin
      chr_valid <= 1'b0;
      chr_perr  <= 1'b0;
      if (tick) begin
        line_prev <= line;
        case (state)
          RX_IDLE: begin
            if (!line && line_prev) begin
              state <= RX_START;
              cnt   <= '0;
            end
          end
          RX_START: begin
            if (cnt == CNT_HALF) begin
              cnt <= '0;
              idx <= '0;
              state <= line ? RX_IDLE : RX_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (cnt == CNT_FULL) begin
              cnt <= '0;
              if (idx == 4'd8) begin
                chr_valid <= 1'b1;
                chr_data  <= dec_now;
                chr_raw   <= sh;
                chr_perr  <= perr_now;
                state     <= RX_IDLE;
              end else begin
                sh[idx[2:0]] <= line;
                idx          <= idx + 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  // A frame lasts several etu, so two back-to-back completions are impossible.
  assert_single_push_R3: assert property (@(posedge clk) disable iff (rst)
    chr_valid |=> !chr_valid);

  // Parity error is only ever flagged together with a completed character.
  assert_perr_with_char_R5: assert property (@(posedge clk) disable iff (rst)
    chr_perr |-> chr_valid);

  // A character cannot be delivered without passing through the start check.
  assert_start_before_data_R2: assert property (@(posedge clk) disable iff (rst)
    (state == RX_IDLE && $past(state) == RX_IDLE && !rst && !$past(rst)) |=> state != RX_DATA);

endmodule

// File: rtl/card_rx_fifo.sv
module card_rx_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [W-1:0]                 push_data,
  input  logic                         pop,
  input  logic [$clog2(DEPTH)-1:0]     tide,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         irq,
  output logic                         overrun
);

  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp, rp_nxt;
  logic [CW-1:0] cnt_nxt;
  logic          push_ok, pop_ok;

  always_comb begin
    push_ok = push && (level != FULL);
    pop_ok  = pop && (level != '0);
    cnt_nxt = level + CW'(push_ok) - CW'(pop_ok);
    rp_nxt  = pop_ok ? ((rp == LAST) ? '0 : rp + 1'b1) : rp;
  end

  // Storage without reset so it maps onto on-chip RAM.
  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp      <= '0;
      rp      <= '0;
      level   <= '0;
      irq     <= 1'b0;
      overrun <= 1'b0;
      head    <= '0;
    end else begin
      if (push_ok) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      rp      <= rp_nxt;
      level   <= cnt_nxt;
      irq     <= cnt_nxt > CW'(tide);
      overrun <= push && !push_ok;
      head    <= (push_ok && wp == rp_nxt) ? push_data : mem[rp_nxt];
    end
  end

  assert_level_cap_R6: assert property (@(posedge clk) disable iff (rst)
    level <= FULL);

  assert_drop_keeps_level_R7: assert property (@(posedge clk) disable iff (rst)
    (push && level == FULL && !pop) |=> level == FULL);

  assert_overrun_when_full_R7: assert property (@(posedge clk) disable iff (rst)
    overrun |-> $past(level) == FULL);

  assert_empty_quiet_irq_R8: assert property (@(posedge clk) disable iff (rst)
    (level == '0) |-> !irq);

endmodule

// File: rtl/card_rx_ts.sv
module card_rx_ts
  import card_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       chr_valid,
  input  logic [7:0] chr_raw,
  output logic       seen,
  output logic       valid,
  output logic       inverse
);

  logic is_direct, is_inverse;

  always_comb begin
    is_direct  = map_bits(chr_raw, 1'b0) == CONV_BYTE_DIRECT;
    is_inverse = map_bits(chr_raw, 1'b1) == CONV_BYTE_INVERSE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen    <= 1'b0;
      valid   <= 1'b0;
      inverse <= 1'b0;
    end else if (chr_valid && !seen) begin
      seen    <= 1'b1;
      valid   <= is_direct || is_inverse;
      inverse <= is_inverse;
    end
  end

  assert_ts_hold_R10: assert property (@(posedge clk) disable iff (rst)
    seen |=> seen && $stable(valid) && $stable(inverse));

  assert_ts_valid_seen_R9: assert property (@(posedge clk) disable iff (rst)
    (valid || inverse) |-> seen);

endmodule

// File: rtl/card_rx_top.sv
module card_rx_top #(
  parameter int OSR   = 16,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       io_line,
  input  logic                       bit_tick,
  input  logic                       cfg_inverse,
  input  logic                       cfg_odd_parity,
  input  logic [$clog2(DEPTH)-1:0]   cfg_tide,
  input  logic                       rd_en,
  output logic [7:0]                 rd_data,
  output logic [$clog2(DEPTH+1)-1:0] rx_level,
  output logic                       rx_irq,
  output logic                       parity_err,
  output logic                       overrun,
  output logic                       ts_seen,
  output logic                       ts_valid,
  output logic                       ts_inverse
);

  logic       chr_valid;
  logic [7:0] chr_data;
  logic [7:0] chr_raw;
  logic       chr_perr;

  card_rx_deser #(.OSR(OSR)) u_deser (
    .clk       (clk),
    .rst       (rst),
    .line      (io_line),
    .tick      (bit_tick),
    .inverse   (cfg_inverse),
    .odd_par   (cfg_odd_parity),
    .chr_valid (chr_valid),
    .chr_data  (chr_data),
    .chr_raw   (chr_raw),
    .chr_perr  (chr_perr)
  );

  card_rx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (chr_valid),
    .push_data (chr_data),
    .pop       (rd_en),
    .tide      (cfg_tide),
    .head      (rd_data),
    .level     (rx_level),
    .irq       (rx_irq),
    .overrun   (overrun)
  );

  card_rx_ts u_ts (
    .clk       (clk),
    .rst       (rst),
    .chr_valid (chr_valid),
    .chr_raw   (chr_raw),
    .seen      (ts_seen),
    .valid     (ts_valid),
    .inverse   (ts_inverse)
  );

  assign parity_err = chr_perr;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (rx_level == '0 && !rx_irq && !ts_seen && !overrun));

endmodule

// File: tb/card_rx_top_test.sv
module card_rx_top_test;

  localparam int OSR     = 16;
  localparam int TDIV    = 4;
  localparam int ETU_CLK = OSR * TDIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       io_line = 1'b1;
  logic       bit_tick = 1'b0;
  logic       cfg_inverse = 1'b0;
  logic       cfg_odd_parity = 1'b0;
  logic [2:0] cfg_tide = 3'd0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic [3:0] rx_level;
  logic       rx_irq, parity_err, overrun, ts_seen, ts_valid, ts_inverse;

  int tests = 0;
  int fails = 0;
  int perr_cnt = 0;
  int ovr_cnt = 0;
  logic [1:0] tdiv = '0;

  always #2 clk = ~clk;

  card_rx_top #(.OSR(OSR), .DEPTH(8)) uut (
    .clk(clk), .rst(rst), .io_line(io_line), .bit_tick(bit_tick),
    .cfg_inverse(cfg_inverse), .cfg_odd_parity(cfg_odd_parity),
    .cfg_tide(cfg_tide), .rd_en(rd_en), .rd_data(rd_data),
    .rx_level(rx_level), .rx_irq(rx_irq), .parity_err(parity_err),
    .overrun(overrun), .ts_seen(ts_seen), .ts_valid(ts_valid),
    .ts_inverse(ts_inverse)
  );

  always @(negedge clk) begin
    tdiv     <= tdiv + 1'b1;
    bit_tick <= (tdiv == 2'd0);
    if (parity_err) perr_cnt <= perr_cnt + 1;
    if (overrun)    ovr_cnt  <= ovr_cnt + 1;
  end

  task automatic check(input string req, input int actual, input int expected);
    tests++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, actual, expected);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic hold_line(input logic v, input int clocks);
    io_line = v;
    repeat (clocks) @(negedge clk);
  endtask

  // Send raw line bits (index 0 first) and a raw parity level, then guard time.
  task automatic send_raw(input logic [7:0] bits, input logic par);
    @(negedge clk);
    hold_line(1'b0, ETU_CLK);
    for (int i = 0; i < 8; i++) hold_line(bits[i], ETU_CLK);
    hold_line(par, ETU_CLK);
    hold_line(1'b1, 3 * ETU_CLK);
  endtask

  // Encode a byte for a given convention and parity mode; bad flips parity.
  task automatic send_byte(input logic [7:0] b, input logic inv, input logic odd,
                           input logic bad);
    logic [7:0] bits;
    logic plog;
    for (int i = 0; i < 8; i++) bits[i] = inv ? ~b[7-i] : b[i];
    plog = (^b) ^ odd ^ bad;
    send_raw(bits, inv ? ~plog : plog);
  endtask

  task automatic pop_one();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_all();
    int lvl;
    int p0;
    int o0;
    logic [7:0] v;

    // R1 reset state
    do_reset();
    check("R1 level", rx_level, 0);
    check("R1 irq", rx_irq, 0);
    check("R1 ts_seen", ts_seen, 0);
    check("R1 ts_valid", ts_valid, 0);
    check("R1 ts_inverse", ts_inverse, 0);
    check("R1 pulses", perr_cnt + ovr_cnt, 0);

    // R9 direct convention byte, then R10 hold
    send_byte(8'h3B, 1'b0, 1'b0, 1'b0);
    check("R9 seen", ts_seen, 1);
    check("R9 valid", ts_valid, 1);
    check("R9 direct", ts_inverse, 0);
    check("R3 data", rd_data, 8'h3B);
    send_byte(8'h3F, 1'b1, 1'b0, 1'b0);
    check("R10 valid held", ts_valid, 1);
    check("R10 inverse held", ts_inverse, 0);
    check("R6 level two", rx_level, 2);
    pop_one();
    check("R3 inverse-coded byte read direct", rd_data, 8'h03);
    pop_one();
    check("R6 drained", rx_level, 0);
    pop_one();
    check("R6 pop on empty", rx_level, 0);

    // R9 inverse convention byte under direct setting
    do_reset();
    send_byte(8'h3F, 1'b1, 1'b0, 1'b0);
    check("R9 inv seen", ts_seen, 1);
    check("R9 inv valid", ts_valid, 1);
    check("R9 inv flag", ts_inverse, 1);
    check("R3 direct view", rd_data, 8'h03);

    // R9 illegal first byte
    do_reset();
    send_byte(8'h55, 1'b0, 1'b0, 1'b0);
    check("R9 bad seen", ts_seen, 1);
    check("R9 bad valid", ts_valid, 0);
    check("R9 bad inverse", ts_inverse, 0);
    pop_one();

    // R2 short low pulses
    hold_line(1'b0, 3 * TDIV);
    hold_line(1'b1, 2 * ETU_CLK);
    check("R2 glitch 3 ticks", rx_level, 0);
    hold_line(1'b0, 6 * TDIV);
    hold_line(1'b1, 2 * ETU_CLK);
    check("R2 glitch 6 ticks", rx_level, 0);
    send_byte(8'hA6, 1'b0, 1'b0, 1'b0);
    check("R2 real frame after glitch", rx_level, 1);
    pop_one();

    // R5 parity
    p0 = perr_cnt;
    send_byte(8'h81, 1'b0, 1'b0, 1'b1);
    check("R5 even bad", perr_cnt - p0, 1);
    check("R5 stored anyway", rx_level, 1);
    check("R5 data", rd_data, 8'h81);
    pop_one();
    cfg_odd_parity = 1'b1;
    send_byte(8'h81, 1'b0, 1'b1, 1'b0);
    check("R5 odd good", perr_cnt - p0, 1);
    cfg_inverse = 1'b1;
    send_byte(8'h5C, 1'b1, 1'b1, 1'b1);
    check("R5 inverse odd bad", perr_cnt - p0, 2);
    pop_one();
    check("R4 data", rd_data, 8'h5C);
    pop_one();

    // R4 R6 R7 R8 sweep over every threshold
    for (int t = 0; t < 8; t++) begin
      cfg_inverse    = t[0];
      cfg_odd_parity = t[1];
      cfg_tide       = 3'(t);
      p0 = perr_cnt;
      o0 = ovr_cnt;
      @(negedge clk);
      check("R8 empty irq", rx_irq, 0);
      for (int k = 0; k < 8; k++) begin
        v = 8'((t * 37 + k * 11 + 5) & 255);
        send_byte(v, t[0], t[1], 1'b0);
        check("R6 level", rx_level, k + 1);
        check("R8 irq", rx_irq, (k + 1 > t) ? 1 : 0);
      end
      send_byte(8'hEE, t[0], t[1], 1'b0);
      check("R7 overrun pulse", ovr_cnt - o0, 1);
      check("R7 level full", rx_level, 8);
      check("R5 no false parity", perr_cnt - p0, 0);
      for (int k = 0; k < 8; k++) begin
        v = 8'((t * 37 + k * 11 + 5) & 255);
        check(t[0] ? "R4 order" : "R3 order", rd_data, v);
        lvl = rx_level;
        pop_one();
        check("R6 pop level", rx_level, lvl - 1);
        check("R8 irq drain", rx_irq, (lvl - 1 > t) ? 1 : 0);
      end
      pop_one();
      check("R6 empty pop", rx_level, 0);
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule